// File: doc/BRIEF.md
# Open-Drain Serial Clock Pacer

This block drives the clock wire of a two-wire serial bus. Its only output towards the wire is a pull-low enable: when the enable is high the pad holds the wire low, and when it is low the wire is released to its pull-up. The block can run a free-running clock, or it can make one rising or one falling transition when a request strobe arrives. A sequencer that owns the data wire and the start and stop conditions uses these single-edge requests to build its bus transactions.

The block never times a phase from its own drive. It takes the sampled wire level and one-cycle rise and fall pulses of that sampled level, and restarts its minimum-stable timer on every edge it observes. Because of this, a device that stretches the clock by holding the wire low simply delays the next phase, and the high phase that follows is timed from the moment the wire really rose. A separate watcher raises a flag when the wire stays low for the minimum-stable time after it was released. This shows that another device is holding the wire down.

Top module: `scl_pacer`

## Requirements
- R1: Out of reset `pull_low` and `stuck_low` are 0, and with `run_cont` low and no requests the drive does not change.
- R2: When a `line_rise` or `line_fall` pulse is sampled at clock edge P, `pull_low` cannot change before edge P+HOLD_CYCLES+1 (HOLD_CYCLES is the minimum-stable parameter). In continuous mode with a wire that follows the drive, it changes exactly at that edge.
- R3: Every observed edge restarts the stable timer, including edges caused by another device. A pending request is therefore delayed until HOLD_CYCLES+1 edges after the last such pulse.
- R4: With `run_cont` high, the block pulls the wire low once the hold time has elapsed and the wire is high. It releases the wire once the hold time has elapsed while it is pulling low. With a bench wire sampled one cycle late, each phase lasts HOLD_CYCLES+2 cycles.
- R5: In continuous mode, if the wire stays low after release, no new pull happens until a rise is observed. The next pull comes HOLD_CYCLES+1 edges after that rise.
- R6: A one-cycle `req_fall` strobe, sampled at edge P while the timer has elapsed, sets `pull_low` at edge P+1. The drive then stays low with no further transition.
- R7: A one-cycle `req_rise` strobe releases the wire in the same way, at edge P+1 when the timer has elapsed.
- R8: A request that arrives before the hold time has elapsed is kept and carried out when it elapses. If `req_fall` and `req_rise` arrive in the same cycle, the fall is kept and the rise is discarded.
- R9: `stuck_low` rises at the HOLD_CYCLES-th consecutive clock edge at which the drive is released and `line_lvl` is 0.
- R10: `stuck_low` clears at the edge that samples a `line_rise` pulse.
- R11: Request strobes sampled while `run_cont` is high are discarded, and they have no effect after continuous mode ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_lvl | input | 1 | Synchronised level of the bus clock wire |
| line_rise | input | 1 | One-cycle pulse on a sampled low-to-high change of the wire |
| line_fall | input | 1 | One-cycle pulse on a sampled high-to-low change of the wire |
| run_cont | input | 1 | Generate a continuous clock while high |
| req_rise | input | 1 | Strobe: release the wire once |
| req_fall | input | 1 | Strobe: pull the wire low once |
| pull_low | output | 1 | Pad enable; 1 holds the wire low |
| stuck_low | output | 1 | Wire released but held low by another device |

## Verification
The embedded properties assume that the edge pulses agree with the sampled level. They assume that a rise pulse comes with `line_lvl` high, a fall pulse comes with it low, and the two never occur in the same cycle. Request strobes are assumed to last one cycle. The bench keeps to these assumptions by modelling the open-drain wire as the inverse of the pull enable OR-ed with an external holder, and by deriving level and pulses from that wire in a single register stage at the falling clock edge. Stretching is injected only while the block has just released the wire, and a one-cycle foreign pulse is injected only while the wire is idle high.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

    // Single-edge request waiting for the hold time to elapse
    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_RISE = 2'd1,
        PEND_FALL = 2'd2
    } pend_e;

    typedef struct packed {
        logic  drive;
        pend_e pend;
    } ctrl_state_t;

endpackage

// File: rtl/scl_hold_timer.sv
module scl_hold_timer #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_rise_i,
    input  logic line_fall_i,
    output logic ready_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_MAX = CW'(HOLD_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic seen_edge;

    always_comb begin
        st_d      = st_q;
        seen_edge = line_rise_i | line_fall_i;
        if (seen_edge) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != HOLD_MAX) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = (st_q.cnt == HOLD_MAX) && !seen_edge;

    // An observed edge always forces a fresh wait
    p_no_ready_after_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_rise_i || line_fall_i) |=> !ready_o);

endmodule

// File: rtl/scl_stuck_watch.sv
module scl_stuck_watch #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_i,
    input  logic line_lvl_i,
    input  logic line_rise_i,
    output logic stuck_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_MAX  = CW'(HOLD_CYCLES);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } watch_t;

    watch_t st_d, st_q;
    logic   held_low;

    always_comb begin
        st_d     = st_q;
        held_low = !drive_i && !line_lvl_i;
        if (held_low) begin
            if (st_q.cnt != HOLD_MAX) begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end else begin
            st_d.cnt = '0;
        end
        if (line_rise_i) begin
            st_d.flag = 1'b0;
        end else if (held_low && (st_q.cnt >= HOLD_LAST)) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stuck_o = st_q.flag;

    p_stuck_clears_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        line_rise_i |=> !stuck_o);

    p_stuck_needs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stuck_o) |-> $past(!drive_i && !line_lvl_i));

endmodule

// File: rtl/scl_edge_ctrl.sv
module scl_edge_ctrl
    import scl_pacer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_cont_i,
    input  logic req_rise_i,
    input  logic req_fall_i,
    input  logic line_lvl_i,
    input  logic ready_i,
    output logic drive_o
);
    ctrl_state_t st_d, st_q;
    pend_e       incoming;

    always_comb begin
        st_d = st_q;
        if (req_fall_i) begin
            incoming = PEND_FALL;
        end else if (req_rise_i) begin
            incoming = PEND_RISE;
        end else begin
            incoming = PEND_NONE;
        end

        if (run_cont_i) begin
            st_d.pend = PEND_NONE;
            if (ready_i) begin
                if (line_lvl_i) begin
                    st_d.drive = 1'b1;
                end else if (st_q.drive) begin
                    st_d.drive = 1'b0;
                end
            end
        end else begin
            if (ready_i && (st_q.pend != PEND_NONE)) begin
                st_d.drive = (st_q.pend == PEND_FALL);
                st_d.pend  = incoming;
            end else if (incoming != PEND_NONE) begin
                st_d.pend = incoming;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.drive <= 1'b0;
            st_q.pend  <= PEND_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign drive_o = st_q.drive;

    // The drive only moves once the timer reports an elapsed hold time
    p_hold_before_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.drive) |-> $past(ready_i));

    // Released but low in continuous mode: keep waiting for the wire
    p_wait_while_stretched_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cont_i && !st_q.drive && !line_lvl_i) |=> !st_q.drive);

    // Nothing left over from continuous mode
    p_cont_leaves_no_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cont_i && !req_rise_i && !req_fall_i) |=> (st_q.pend == PEND_NONE));

endmodule

// File: rtl/scl_pacer.sv
module scl_pacer #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_lvl,
    input  logic line_rise,
    input  logic line_fall,
    input  logic run_cont,
    input  logic req_rise,
    input  logic req_fall,
    output logic pull_low,
    output logic stuck_low
);
    logic hold_ready;
    logic drive;

    scl_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_rise_i (line_rise),
        .line_fall_i (line_fall),
        .ready_o     (hold_ready)
    );

    scl_edge_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_cont_i (run_cont),
        .req_rise_i (req_rise),
        .req_fall_i (req_fall),
        .line_lvl_i (line_lvl),
        .ready_i    (hold_ready),
        .drive_o    (drive)
    );

    scl_stuck_watch #(.HOLD_CYCLES(HOLD_CYCLES)) u_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .drive_i     (drive),
        .line_lvl_i  (line_lvl),
        .line_rise_i (line_rise),
        .stuck_o     (stuck_low)
    );

    assign pull_low = drive;

    p_reset_released_r1: assert property (@(posedge clk)
        !rst_n |=> (!pull_low && !stuck_low) || rst_n);

endmodule

// File: tb/scl_pacer_test.sv
module scl_pacer_test;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_lvl = 1'b1, line_rise = 1'b0, line_fall = 1'b0;
    logic run_cont = 1'b0, req_rise = 1'b0, req_fall = 1'b0;
    logic pull_low, stuck_low;

    int vectors = 0, errs = 0, cyc = 0;
    int stretch_len = 0, stretch_tok = 0, stretch_used = 0, ext_cnt = 0;
    int force_tok = 0, force_used = 0;
    logic drv_seen = 1'b0, prev_bus = 1'b1;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scl_pacer #(.HOLD_CYCLES(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .line_rise(line_rise),
        .line_fall(line_fall), .run_cont(run_cont), .req_rise(req_rise),
        .req_fall(req_fall), .pull_low(pull_low), .stuck_low(stuck_low)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Open-drain wire model, sampled once per cycle at the falling edge
    always @(negedge clk) begin : wire_model
        logic bus, ext;
        if (!pull_low && drv_seen && stretch_tok != stretch_used) begin
            ext_cnt = stretch_len;
            stretch_used = stretch_tok;
        end
        drv_seen = pull_low;
        ext = (ext_cnt > 0) || (force_tok != force_used);
        force_used = force_tok;
        if (ext_cnt > 0) ext_cnt--;
        bus = !(pull_low || ext);
        line_rise = bus && !prev_bus;
        line_fall = !bus && prev_bus;
        line_lvl = bus;
        prev_bus = bus;
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_val(input logic v, output int at);
        at = -1;
        for (int i = 0; i < 1000; i++) begin
            tick();
            if (pull_low == v) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic count_moves(input int n, output int moves);
        logic last;
        last = pull_low;
        moves = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (pull_low != last) moves++;
            last = pull_low;
        end
    endtask

    task automatic strobe(input logic f, input logic r, output int t0);
        req_fall = f;
        req_rise = r;
        t0 = cyc;
        tick();
        req_fall = 1'b0;
        req_rise = 1'b0;
    endtask

    initial begin : watchdog
        #2000000;
        if (!done) begin
            errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin : main
        int t0, at, x, y, prev_y, moves, stk;
        for (int i = 0; i < 5; i++) tick();
        rst_n = 1'b1;
        tick();
        check("R1 pull_low after reset", int'(pull_low), 0);
        check("R1 stuck_low after reset", int'(stuck_low), 0);
        count_moves(20, moves);
        check("R1 idle moves", moves, 0);

        // single fall, then stays low
        strobe(1'b1, 1'b0, t0);
        wait_val(1'b1, at);
        check("R6 fall request edge", at, t0 + 2);
        count_moves(3 * HOLD, moves);
        check("R6 single transition", moves, 0);
        strobe(1'b0, 1'b1, t0);
        wait_val(1'b0, at);
        check("R7 rise request edge", at, t0 + 2);
        count_moves(2 * HOLD + 4, moves);

        // request during hold is remembered
        strobe(1'b1, 1'b0, t0);
        wait_val(1'b1, x);
        strobe(1'b0, 1'b1, t0);
        wait_val(1'b0, at);
        check("R8 held rise request", at, x + HOLD + 2);
        count_moves(2 * HOLD + 4, moves);

        // simultaneous strobes: fall wins
        strobe(1'b1, 1'b1, t0);
        wait_val(1'b1, at);
        check("R8 simultaneous fall wins", at, t0 + 2);
        count_moves(3 * HOLD, moves);
        check("R8 rise discarded", moves, 0);
        strobe(1'b0, 1'b1, t0);
        wait_val(1'b0, at);
        check("R7 release after simultaneous", at, t0 + 2);
        count_moves(2 * HOLD + 4, moves);

        // foreign low pulse restarts the timer
        force_tok++;
        strobe(1'b1, 1'b0, t0);
        wait_val(1'b1, at);
        check("R3 foreign edge delays request", at, t0 + HOLD + 3);
        count_moves(2 * HOLD + 4, moves);
        strobe(1'b0, 1'b1, t0);
        wait_val(1'b0, at);
        check("R7 release after foreign pulse", at, t0 + 2);
        count_moves(2 * HOLD + 4, moves);

        // continuous mode, sweep of stretch lengths
        run_cont = 1'b1;
        wait_val(1'b1, prev_y);
        for (int s = 0; s <= HOLD + 3; s++) begin
            stretch_len = s;
            stretch_tok++;
            wait_val(1'b0, x);
            check("R2 R4 low phase length", x - prev_y, HOLD + 2);
            stk = 0;
            y = -1;
            for (int i = 0; i < 1000; i++) begin
                tick();
                if (pull_low) begin
                    y = cyc;
                    break;
                end
                if (stuck_low) stk++;
            end
            check("R5 stretched high phase", y - x, s + HOLD + 2);
            check("R9 stuck cycles", stk, (s >= HOLD) ? (s + 1 - HOLD) : 0);
            check("R10 stuck cleared after rise", int'(stuck_low), 0);
            prev_y = y;
        end

        // strobe during continuous mode is discarded
        req_rise = 1'b1;
        tick();
        req_rise = 1'b0;
        run_cont = 1'b0;
        count_moves(3 * HOLD, moves);
        check("R11 request in continuous mode discarded", moves, 0);
        check("R11 drive still low", int'(pull_low), 1);
        strobe(1'b0, 1'b1, t0);
        wait_val(1'b0, at);
        check("R7 release after continuous", at, t0 + 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule